// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt request pins, eight by default, and turns each pin into an interrupt request line. Each pin has its own two-bit sense field in a control register. The field selects one of four modes: active-low level, falling edge, rising edge, or any edge. The pins are asynchronous, so every pin passes through a two-stage synchronizer before any detection takes place. An edge is found by comparing the newest synchronized sample with the one taken a cycle earlier.

In the edge modes, a detected edge sets a sticky pending bit, and that bit drives the request output. Software clears the bit by writing 1 to it in the status register. The interrupt handling side can also clear it by pulsing the matching acknowledge input. In level mode nothing is latched, and the request simply follows the inverted, synchronized pin. Changing a pin's sense code discards that pin's pending bit, so an edge caught under the old mode cannot produce a request under the new one.

The register port holds the control register at address 0 and the request status at address 1. A write takes effect on the clock edge where `reg_wr` is high. Read data is registered and reflects the address presented at the previous edge.

Top module: `irq_sense_ctrl`

## Requirements
- R1: A synchronous reset sets the control register to all zeros, which puts every pin in level mode. It also clears every pending bit and drives every request output to 0. Its synchronizer stages are preset to high, so releasing reset with the pins high creates no request.
- R2: The control register is 16 bits wide and every bit can be read and written at address 0. Pin n's sense field occupies bits 2n+1:2n, so pin 7 uses 15:14 and pin 0 uses 1:0. The codes are 00 low level, 01 falling, 10 rising and 11 both edges.
- R3: With code 00, a pin's request is high exactly while the synchronized pin is low, and nothing is latched. Writing 1 to that pin's status bit while the pin is held low leaves the request high.
- R4: With code 01, a high-to-low transition of the pin sets its pending bit, and a low-to-high transition does not.
- R5: With code 10, a low-to-high transition of the pin sets its pending bit, and a high-to-low transition does not.
- R6: With code 11, a transition in either direction sets the pin's pending bit.
- R7: In the edge modes, a pending bit stays set until a write of 1 to status bit n at address 1 or a high level on `irq_ack[n]` at a clock edge. Writing 0 to that bit has no effect.
- R8: When an edge is detected in the same cycle as a clear, the pending bit stays set.
- R9: A control write that changes pin n's sense code clears pin n's pending bit. A write that leaves the code unchanged keeps it.
- R10: A change on a pin shows up on its request output after exactly three rising clock edges. A clear or a sense code write shows up on the request output at the edge where it is sampled.
- R11: A read of address 1 returns the request outputs in bits 7:0, with the upper bits 0. A read of address 0 returns the control register. Read data appears one edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | NUM_PINS | Asynchronous external request pins |
| irq_ack | input | NUM_PINS | Per-pin acknowledge that clears a pending bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 2*NUM_PINS | Register write data |
| reg_rdata | output | 2*NUM_PINS | Registered read data |
| irq_req | output | NUM_PINS | Registered interrupt request per pin |

## Verification
The hardest case to reach is an edge that arrives on exactly the clock edge where a clear is applied. The edge appears only three edges after the pin moves, so the clear has to be placed two cycles after the pin is driven. A directed case sets up this alignment for a clear written by software. The random phase toggles pins often and issues acknowledges and status writes at a high rate, so acknowledge collisions and collisions with sense code rewrites also occur many times. Every cycle is compared against a bench model of the sense rules.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int FIELD_W = 2;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/irqs_sync.sv
module irqs_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  // Preset high: an idle pin is high, so reset release creates no edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqs_regs.sv
module irqs_regs
  import irqs_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int CTRL_W  = FIELD_W * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic                addr,
  input  logic [CTRL_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] req,
  output logic [CTRL_W-1:0]   ctrl_q,
  output logic [CTRL_W-1:0]   ctrl_d,
  output logic [NUM_PINS-1:0] field_chg,
  output logic [NUM_PINS-1:0] clr_wr,
  output logic [CTRL_W-1:0]   rdata
);
  logic ctrl_we, stat_we;

  assign ctrl_we = wr && (addr == ADDR_CTRL);
  assign stat_we = wr && (addr == ADDR_STAT);
  assign ctrl_d  = ctrl_we ? wdata : ctrl_q;
  assign clr_wr  = stat_we ? wdata[NUM_PINS-1:0] : '0;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_chg
    assign field_chg[n] = ctrl_d[FIELD_W*n +: FIELD_W] != ctrl_q[FIELD_W*n +: FIELD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rdata  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      rdata  <= (addr == ADDR_STAT) ? CTRL_W'(req) : ctrl_q;
    end
  end
endmodule

// File: rtl/irqs_pin_detect.sv
module irqs_pin_detect
  import irqs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sync,
  input  sense_e mode_q,
  input  sense_e mode_d,
  input  logic   field_chg,
  input  logic   clr,
  output logic   req
);
  logic prev, pend_q, pend_d, rise, fall, hit;

  assign rise = sync & ~prev;
  assign fall = ~sync & prev;

  always_comb begin
    unique case (mode_q)
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      SENSE_BOTH: hit = rise | fall;
      default:    hit = 1'b0;
    endcase
  end

  // Mode change discards stale state; otherwise a new edge beats a clear.
  always_comb begin
    if (field_chg)  pend_d = 1'b0;
    else if (hit)   pend_d = 1'b1;
    else if (clr)   pend_d = 1'b0;
    else            pend_d = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= 1'b1;
      pend_q <= 1'b0;
      req    <= 1'b0;
    end else begin
      prev   <= sync;
      pend_q <= pend_d;
      req    <= (mode_d == SENSE_LOW) ? ~sync : pend_d;
    end
  end
endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import irqs_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PINS-1:0]       irq_pin,
  input  logic [NUM_PINS-1:0]       irq_ack,
  input  logic                      reg_wr,
  input  logic                      reg_addr,
  input  logic [2*NUM_PINS-1:0]     reg_wdata,
  output logic [2*NUM_PINS-1:0]     reg_rdata,
  output logic [NUM_PINS-1:0]       irq_req
);
  localparam int CTRL_W = FIELD_W * NUM_PINS;

  logic [NUM_PINS-1:0] pin_s, field_chg, clr_wr;
  logic [CTRL_W-1:0]   ctrl_q, ctrl_d;

  irqs_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_pin),
    .q   (pin_s)
  );

  irqs_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .req       (irq_req),
    .ctrl_q    (ctrl_q),
    .ctrl_d    (ctrl_d),
    .field_chg (field_chg),
    .clr_wr    (clr_wr),
    .rdata     (reg_rdata)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    irqs_pin_detect u_det (
      .clk       (clk),
      .rst       (rst),
      .sync      (pin_s[n]),
      .mode_q    (sense_e'(ctrl_q[FIELD_W*n +: FIELD_W])),
      .mode_d    (sense_e'(ctrl_d[FIELD_W*n +: FIELD_W])),
      .field_chg (field_chg[n]),
      .clr       (clr_wr[n] | irq_ack[n]),
      .req       (irq_req[n])
    );
  end
endmodule

// File: rtl/irqs_checker.sv
module irqs_checker #(
  parameter int NUM_PINS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_PINS-1:0]   irq_pin,
  input logic [NUM_PINS-1:0]   irq_ack,
  input logic                  reg_wr,
  input logic                  reg_addr,
  input logic [2*NUM_PINS-1:0] reg_wdata,
  input logic [NUM_PINS-1:0]   irq_req,
  input logic [2*NUM_PINS-1:0] ctrl
);
  logic [2:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R1: reset empties requests and control
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (irq_req == '0 && ctrl == '0));

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_p
    // R3 / R10: level mode follows the inverted pin three edges later
    p_level_r3: assert property (@(posedge clk) disable iff (rst)
      (age >= 3'd5 && ctrl[2*n +: 2] == 2'b00) |-> (irq_req[n] == !$past(irq_pin[n], 3)));

    // R4 / R8: falling edge sets request even with a clear present
    p_fall_r4: assert property (@(posedge clk) disable iff (rst)
      (age >= 3'd5 && ctrl[2*n +: 2] == 2'b01 && $past(ctrl[2*n +: 2]) == 2'b01
       && !$past(irq_pin[n], 3) && $past(irq_pin[n], 4)) |-> irq_req[n]);

    // R5: rising edge sets request
    p_rise_r5: assert property (@(posedge clk) disable iff (rst)
      (age >= 3'd5 && ctrl[2*n +: 2] == 2'b10 && $past(ctrl[2*n +: 2]) == 2'b10
       && $past(irq_pin[n], 3) && !$past(irq_pin[n], 4)) |-> irq_req[n]);

    // R6: any edge sets request
    p_both_r6: assert property (@(posedge clk) disable iff (rst)
      (age >= 3'd5 && ctrl[2*n +: 2] == 2'b11 && $past(ctrl[2*n +: 2]) == 2'b11
       && ($past(irq_pin[n], 3) != $past(irq_pin[n], 4))) |-> irq_req[n]);

    // R7: pending request holds without a clear or control write
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (age >= 3'd1 && ctrl[2*n +: 2] != 2'b00 && irq_req[n] && !irq_ack[n]
       && !(reg_wr && reg_addr && reg_wdata[n]) && !(reg_wr && !reg_addr))
      |=> irq_req[n]);

    // R9: changing an edge-mode sense code drops the request
    p_chg_clr_r9: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && !reg_addr && reg_wdata[2*n +: 2] != ctrl[2*n +: 2]
       && reg_wdata[2*n +: 2] != 2'b00) |=> !irq_req[n]);
  end
endmodule

bind irq_sense_ctrl irqs_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_pin   (irq_pin),
  .irq_ack   (irq_ack),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_req   (irq_req),
  .ctrl      (ctrl_q)
);

// File: tb/tb_irq_sense_ctrl.sv
`timescale 1ns/1ps
module tb_irq_sense_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin = 8'hFF, ack = 8'h00;
  logic        we = 1'b0, addr = 1'b0;
  logic [15:0] wd = 16'h0000;
  logic [15:0] rdata;
  logic [7:0]  req;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_sense_ctrl dut (
    .clk(clk), .rst(rst), .irq_pin(pin), .irq_ack(ack),
    .reg_wr(we), .reg_addr(addr), .reg_wdata(wd),
    .reg_rdata(rdata), .irq_req(req)
  );

  // Bench model of the sense rules
  logic [7:0]  m_s1, m_s2, m_prev, m_pend, m_req;
  logic [15:0] m_ctrl, m_rd;

  task automatic model_step();
    logic [15:0] cn;
    logic [7:0]  pn, rq;
    logic [1:0]  om, nm;
    logic        r, f, hit, clr;
    if (rst) begin
      m_s1 = 8'hFF; m_s2 = 8'hFF; m_prev = 8'hFF;
      m_pend = 0; m_req = 0; m_ctrl = 0; m_rd = 0;
    end else begin
      cn = (we && !addr) ? wd : m_ctrl;
      for (int n = 0; n < 8; n++) begin
        om  = m_ctrl[2*n +: 2];
        nm  = cn[2*n +: 2];
        r   = m_s2[n] & !m_prev[n];
        f   = !m_s2[n] & m_prev[n];
        hit = (om == 2'b01 && f) || (om == 2'b10 && r) || (om == 2'b11 && (r || f));
        clr = ack[n] || (we && addr && wd[n]);
        if (om != nm)  pn[n] = 1'b0;
        else if (hit)  pn[n] = 1'b1;
        else if (clr)  pn[n] = 1'b0;
        else           pn[n] = m_pend[n];
        rq[n] = (nm == 2'b00) ? !m_s2[n] : pn[n];
      end
      m_rd   = addr ? {8'h00, m_req} : m_ctrl;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
      m_pend = pn; m_req = rq; m_ctrl = cn;
    end
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: model follows the edge, outputs compared 2 ns later.
  task automatic tick(input int k = 1);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      model_step();
      #2;
      check({8'h00, req}, {8'h00, m_req}, "R10 request vs model");
      check(rdata, m_rd, "R11 read data vs model");
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    we = 1'b1; addr = a; wd = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    addr = a;
    tick();
    v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (R10 progress)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    tick(3);
    rst = 1'b0;
    tick();
    check({8'h00, req}, 16'h0000, "R1 requests after reset");
    rd(1'b0, v);
    check(v, 16'h0000, "R1 control after reset");

    wr(1'b0, 16'h9C36);
    rd(1'b0, v);
    check(v, 16'h9C36, "R2 control readback");
    // pin2 falling, pin3 rising, pin5 both, others level
    wr(1'b0, 16'h0C90);

    pin[2] = 1'b0; tick(2);
    check({15'h0, req[2]}, 16'h0, "R10 no request before third edge");
    tick();
    check({15'h0, req[2]}, 16'h1, "R4 falling edge sets request");
    pin[2] = 1'b1; tick(4);
    check({15'h0, req[2]}, 16'h1, "R4 rising edge ignored, R7 sticky");
    wr(1'b1, 16'h0000);
    check({15'h0, req[2]}, 16'h1, "R7 write 0 no effect");
    ack[2] = 1'b1; tick(); ack[2] = 1'b0;
    check({15'h0, req[2]}, 16'h0, "R7 acknowledge clears");

    pin[3] = 1'b0; tick(4);
    check({15'h0, req[3]}, 16'h0, "R5 falling edge ignored");
    pin[3] = 1'b1; tick(3);
    check({15'h0, req[3]}, 16'h1, "R5 rising edge sets request");
    wr(1'b1, 16'h0008);
    check({15'h0, req[3]}, 16'h0, "R7 write 1 clears");

    pin[5] = 1'b0; tick(3);
    check({15'h0, req[5]}, 16'h1, "R6 falling edge sets request");
    pin[5] = 1'b1; tick(2);
    wr(1'b1, 16'h0020);
    check({15'h0, req[5]}, 16'h1, "R8 edge wins over clear");
    wr(1'b1, 16'h0020);
    check({15'h0, req[5]}, 16'h0, "R7 clear after collision");
    pin[5] = 1'b0; tick(3);
    check({15'h0, req[5]}, 16'h1, "R6 second edge sets request");
    ack[5] = 1'b1; tick(); ack[5] = 1'b0;

    pin[3] = 1'b0; tick(2); pin[3] = 1'b1; tick(3);
    check({15'h0, req[3]}, 16'h1, "R9 pending before rewrite");
    wr(1'b0, 16'h0C90);
    check({15'h0, req[3]}, 16'h1, "R9 same code keeps pending");
    wr(1'b0, 16'h0CD0);
    check({15'h0, req[3]}, 16'h0, "R9 new code clears pending");

    pin[0] = 1'b0; tick(2);
    check({15'h0, req[0]}, 16'h0, "R3 level latency");
    tick();
    check({15'h0, req[0]}, 16'h1, "R3 low level requests");
    wr(1'b1, 16'h0001); tick();
    check({15'h0, req[0]}, 16'h1, "R3 clear ignored while low");
    rd(1'b1, v); rd(1'b1, v);
    check(v, 16'h0001, "R11 status read");
    pin[0] = 1'b1; tick(3);
    check({15'h0, req[0]}, 16'h0, "R3 released pin drops request");

    for (int c = 0; c < 3000; c++) begin
      pin  = pin ^ (8'($urandom) & 8'($urandom));
      ack  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      we   = ($urandom % 6) == 0;
      addr = 1'($urandom);
      wd   = 16'($urandom);
      tick();
    end
    we = 1'b0; ack = 8'h00;
    tick(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule